// File: doc/BRIEF.md
# Blanking-Interval Horizontal Shift-Clock Widener

This block drives the horizontal shift clocks of an image sensor. There are two complementary groups, and each group has a parameterised number of pins. The block runs from an edge clock at twice the pixel rate. Outside the horizontal blanking window both groups toggle on every edge-clock tick, so each pin completes one period per pixel.

Inside the blanking window the clocks can be slowed. The slowdown follows a 1/(2n) law, where n is a 4-bit width code. A code of n makes each half-period last n pixels, which is 2n ticks. The output frequency is then 1/(2n) of the pixel rate: 1/2, 1/4, and so on down to 1/30.

The blanking flag comes from the blanking pattern generator, and a 2-bit mode input goes with it. Widening is allowed only in blanking modes 0 and 1. When blanking begins, the divider restarts so that the first wide pulse lines up with the start of the window. When blanking ends, pixel-rate toggling resumes on the next tick.

Top module: `hclk_widener`

## Requirements
- R1: While reset is high, every group-A pin reads 0 and every group-B pin reads 1 after the next tick.
- R2: With the blanking flag low, group A inverts on every tick whatever the mode and code hold.
- R3: With the blanking flag high and width code 0, group A inverts on every tick.
- R4: With the blanking flag high, mode 0 (2'b00) or mode 1 (2'b01), and code n from 1 to 15, group A holds each level for exactly 2n ticks. This gives a period of 4n ticks, which is 2n pixels.
- R5: On the first tick at which the blanking flag is seen high with widening allowed, the divider restarts and group A is driven to 1. That high level then lasts the full 2n ticks.
- R6: In mode 2 (2'b10), and in reserved mode 3 (2'b11), group A inverts on every tick during blanking for any code.
- R7: On the first tick at which the blanking flag is seen low after a widened stretch, group A inverts.
- R8: Every group-B pin is the exact inverse of the group-A pins on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Edge clock, twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| blank_i | input | 1 | High while the line is inside horizontal blanking |
| mode_i | input | 2 | Current blanking pattern mode (0, 1, 2; 3 reserved) |
| width_code_i | input | 4 | Widening code n; 0 disables widening |
| ph_a_o | output | NUM_PAIRS | Group-A horizontal clock pins |
| ph_b_o | output | NUM_PAIRS | Group-B horizontal clock pins, inverse of group A |

## Verification
Suppose the half-period counter or its terminal compare is wrong. The first widened level is then too short or too long, and this shows on group A within 2n+1 ticks of blanking start. A missed restart leaves that first level low, or leaves it shortened by stale count, and this is visible on the very first tick of blanking. A wrong mode or code gate shows up as a one-tick toggle where a held level is expected, or the other way round. The bench therefore compares every tick of each blanking window against the 1/(2n) sequence.

// File: rtl/hclkw_pkg.sv
package hclkw_pkg;

    localparam int CODE_W = 4;
    localparam int CNT_W  = CODE_W + 1;

    typedef enum logic [1:0] {
        HB_MODE0    = 2'd0,
        HB_MODE1    = 2'd1,
        HB_MODE2    = 2'd2,
        HB_MODE_RSV = 2'd3
    } hb_mode_e;

    typedef struct packed {
        logic wide;     // slowed operation requested this tick
        logic restart;  // blanking just began: realign divider
    } div_ctl_t;

    function automatic logic mode_allows_wide(hb_mode_e m);
        return (m == HB_MODE0) || (m == HB_MODE1);
    endfunction

    // last count value of a half-period of 2n ticks
    function automatic logic [CNT_W-1:0] half_last(logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] twice;
        twice = {code, 1'b0};
        return twice - {{(CNT_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/hclkw_ctrl.sv
module hclkw_ctrl
    import hclkw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              blank_i,
    input  hb_mode_e          mode_i,
    input  logic [CODE_W-1:0] code_i,
    output div_ctl_t          ctl_o
);

    logic blank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b0;
        end else begin
            blank_q <= blank_i;
        end
    end

    always_comb begin
        ctl_o.wide    = blank_i && mode_allows_wide(mode_i) && (code_i != '0);
        ctl_o.restart = blank_i && !blank_q;
    end

endmodule

// File: rtl/hclkw_div.sv
module hclkw_div
    import hclkw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  div_ctl_t          ctl_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              ph_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = half_last(code_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_o <= 1'b0;
            cnt  <= '0;
        end else if (!ctl_i.wide) begin
            ph_o <= ~ph_o;
            cnt  <= '0;
        end else if (ctl_i.restart) begin
            ph_o <= 1'b1;
            cnt  <= '0;
        end else if (cnt >= last) begin
            ph_o <= ~ph_o;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hclkw_fanout.sv
module hclkw_fanout #(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 ph_i,
    output logic [NUM_PAIRS-1:0] ph_a_o,
    output logic [NUM_PAIRS-1:0] ph_b_o
);

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign ph_a_o[g] = ph_i;
        assign ph_b_o[g] = ~ph_i;
    end

endmodule

// File: rtl/hclk_widener.sv
module hclk_widener
    import hclkw_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 blank_i,
    input  logic [1:0]           mode_i,
    input  logic [3:0]           width_code_i,
    output logic [NUM_PAIRS-1:0] ph_a_o,
    output logic [NUM_PAIRS-1:0] ph_b_o
);

    div_ctl_t ctl;
    logic     ph;

    hclkw_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .blank_i (blank_i),
        .mode_i  (hb_mode_e'(mode_i)),
        .code_i  (width_code_i),
        .ctl_o   (ctl)
    );

    hclkw_div u_div (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .code_i (width_code_i),
        .ph_o   (ph)
    );

    hclkw_fanout #(.NUM_PAIRS(NUM_PAIRS)) u_fan (
        .ph_i   (ph),
        .ph_a_o (ph_a_o),
        .ph_b_o (ph_b_o)
    );

endmodule

// File: rtl/hclkw_chk.sv
module hclkw_chk #(
    parameter int NUM_PAIRS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 blank_i,
    input logic [1:0]           mode_i,
    input logic [3:0]           width_code_i,
    input logic [NUM_PAIRS-1:0] ph_a_o,
    input logic [NUM_PAIRS-1:0] ph_b_o
);

    logic wide;
    assign wide = blank_i && (mode_i[1] == 1'b0) && (width_code_i != 4'd0);

    // R1
    reset_level_chk: assert property (@(posedge clk)
        rst |=> (ph_a_o == '0) && (ph_b_o == '1));

    // R2
    narrow_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !wide |=> (ph_a_o[0] != $past(ph_a_o[0])));

    // R5
    restart_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wide && !$past(blank_i)) |=> ph_a_o[0]);

    // R4
    wide_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wide && $past(wide) && (ph_a_o[0] != $past(ph_a_o[0]))) |=> $stable(ph_a_o[0]));

    // R8
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        ph_b_o == ~ph_a_o);

endmodule

bind hclk_widener hclkw_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .blank_i      (blank_i),
    .mode_i       (mode_i),
    .width_code_i (width_code_i),
    .ph_a_o       (ph_a_o),
    .ph_b_o       (ph_b_o)
);

// File: tb/sim_hclk_widener.sv
`timescale 1ns/1ps
module sim_hclk_widener;

    localparam int NP = 4;
    localparam int NV = 10;
    // {mode, code, ticks in blanking}
    localparam logic [15:0] VEC [NV] = '{
        {2'd0, 4'd1,  10'd12},
        {2'd1, 4'd2,  10'd20},
        {2'd0, 4'd15, 10'd130},
        {2'd1, 4'd7,  10'd60},
        {2'd0, 4'd0,  10'd10},
        {2'd2, 4'd5,  10'd24},
        {2'd3, 4'd3,  10'd12},
        {2'd1, 4'd0,  10'd8},
        {2'd0, 4'd4,  10'd40},
        {2'd2, 4'd15, 10'd16}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          blank = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [3:0]    code = 4'd0;
    logic [NP-1:0] ph_a;
    logic [NP-1:0] ph_b;

    int checks = 0;
    int errors = 0;
    logic prev;

    always #10 clk = ~clk;

    hclk_widener #(.NUM_PAIRS(NP)) u0 (
        .clk          (clk),
        .rst          (rst),
        .blank_i      (blank),
        .mode_i       (mode),
        .width_code_i (code),
        .ph_a_o       (ph_a),
        .ph_b_o       (ph_b)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_compl(input string req);
        check(ph_b == ~ph_a, req, ph_b, ~ph_a);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        check(ph_a == '0, "R1", ph_a, '0);
        check(ph_b == '1, "R1", ph_b, '1);
        rst = 1'b0;
        step();
        prev = ph_a[0];

        for (int i = 0; i < NV; i++) begin
            int m, n, len;
            logic wide_exp;
            m   = int'(VEC[i][15:14]);
            n   = int'(VEC[i][13:10]);
            len = int'(VEC[i][9:0]);
            wide_exp = (m < 2) && (n != 0);
            mode = 2'(m);
            code = 4'(n);
            blank = 1'b0;
            // R2: outside blanking toggles every tick
            for (int k = 0; k < 3; k++) begin
                step();
                check(ph_a[0] != prev, "R2", ph_a, {NP{~prev}});
                prev = ph_a[0];
            end
            blank = 1'b1;
            for (int j = 0; j < len; j++) begin
                step();
                if (wide_exp) begin
                    logic e;
                    e = ((j / (2 * n)) % 2) == 0;
                    check(ph_a == {NP{e}}, (j == 0) ? "R5" : "R4", ph_a, {NP{e}});
                end else begin
                    check(ph_a[0] != prev, (n == 0) ? "R3" : "R6", ph_a, {NP{~prev}});
                end
                check_compl("R8");
                prev = ph_a[0];
            end
            blank = 1'b0;
            step();
            check(ph_a[0] != prev, "R7", ph_a, {NP{~prev}});
            check_compl("R8");
            prev = ph_a[0];
        end

        // R5: short gap then re-entry realigns the first wide level
        mode = 2'd1;
        code = 4'd3;
        blank = 1'b1;
        for (int j = 0; j < 9; j++) step();
        check(ph_a == '0, "R4", ph_a, '0);
        blank = 1'b0;
        step();
        check(ph_a == '1, "R7", ph_a, '1);
        blank = 1'b1;
        step();
        check(ph_a == '1, "R5", ph_a, '1);
        for (int j = 1; j < 6; j++) step();
        check(ph_a == '1, "R5", ph_a, '1);
        step();
        check(ph_a == '0, "R4", ph_a, '0);

        // R1: reset in the middle of a widened stretch
        rst = 1'b1;
        step();
        check(ph_a == '0, "R1", ph_a, '0);
        check(ph_b == '1, "R1", ph_b, '1);
        blank = 1'b0;
        rst = 1'b0;
        step();
        check(ph_a == '1, "R2", ph_a, '1);

        finish_run();
    end

endmodule